// File: doc/BRIEF.md
# Support-Thread Request Queue with Spawn Arbitration

This block holds support-thread requests that were raised when watched data changed, and hands them to a small pool of hardware execution contexts. Each request carries a start PC, a region identifier, the address whose change raised it, and one live-in argument word. Pending requests sit in a compacting FIFO. Each cycle a dispatcher looks at the pending entries from oldest to youngest. It picks the first one that it can act on and decides its fate against the contexts that are already occupied.

Three outcomes are possible for the chosen request:
- If its region already has a thread running with the same trigger address, that thread is aborted and the context is reloaded.
- If no context holds the region, the request takes the lowest free context.
- If no context is free, the request is discarded and the status table is told to mark the region invalid.

A request whose region is running with a different trigger address stays queued. It does not hold back younger requests for other regions.

After a context is assigned, a configurable transfer delay elapses before the launch command reaches the context. The status table can purge every pending request of a region when the main thread arrives there first. The contexts are modelled only by busy flags and a completion strobe.

Top module: `thread_spawn_queue`

## Requirements
- R1: The queue holds at most DEPTH pending requests. `enqReady` is low exactly when DEPTH requests are pending. A request offered while `enqReady` is low is not taken, and it is accepted once space frees while it is still offered.
- R2: A chosen request whose region occupies no context takes the lowest-numbered free context. One cycle after the selection cycle, `statusValid` pulses with `statusCode` = 0 (spawned) and the request's region, and that context's `ctxBusy` bit is set.
- R3: Exactly XFER cycles after the spawned or replaced status pulse, `launchValid` pulses for one cycle. It carries the context index, PC, trigger address and argument of the request.
- R4: A chosen request whose region is running with the same trigger address pulses `abortVec` (one-hot, the occupied context) together with `statusCode` = 1 (replaced). The context restarts its transfer with the new request, and any launch still due from the old request is suppressed.
- R5: A request whose region is running with a different trigger address stays pending and produces no status pulse. It is chosen once that context finishes.
- R6: A pending request that must wait does not prevent a younger request for another region from being dispatched.
- R7: A chosen request that finds no free context is removed from the queue. It produces `statusCode` = 2 (dropped) with its region, and it produces no launch and no abort.
- R8: A `rmValid` pulse removes every pending request whose region equals `rmRegion`, and the queue compacts. A request enqueued in the same cycle is kept. A request being removed is never dispatched, and the freed space shows on `enqReady` in the next cycle.
- R9: A `ctxDone` bit frees its context only after that context's launch has been issued. During the transfer delay, the bit is ignored.
- R10: Among requests that can be acted on, the oldest is chosen first.
- R11: After reset the queue is empty, all contexts are free, `enqReady` is high, and no status, launch or abort is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enqValid | input | 1 | New request offered |
| enqReady | output | 1 | Queue can accept a request |
| enqPc | input | PC_W | Support-thread start PC |
| enqRegion | input | REG_W | Region identifier |
| enqAddr | input | ADDR_W | Trigger address |
| enqArg | input | ARG_W | Live-in argument |
| rmValid | input | 1 | Purge pending requests of a region |
| rmRegion | input | REG_W | Region to purge |
| ctxDone | input | NCTX | Per-context completion strobe |
| ctxBusy | output | NCTX | Per-context occupied flag |
| abortVec | output | NCTX | One-hot abort of a running thread |
| launchValid | output | 1 | Launch command valid |
| launchCtx | output | CTX_W | Context being launched |
| launchPc | output | PC_W | Launched start PC |
| launchAddr | output | ADDR_W | Launched trigger address |
| launchArg | output | ARG_W | Launched argument |
| statusValid | output | 1 | Status report to the status table |
| statusCode | output | 2 | 0 spawned, 1 replaced, 2 dropped |
| statusRegion | output | REG_W | Region the report refers to |

## Verification
The bench builds the block with DEPTH=4, NCTX=2, XFER=3 and a 3-bit region field. With a queue of four entries, the full-queue stall and the purge of a full queue are reached in a few pushes. With two contexts, both can be saturated, so the dropped outcome can be forced. A short transfer delay lets every launch be checked at its exact cycle. It also lets a replacement land in the very cycle the old launch was due. The eight-value region field allows a sweep that spawns, launches and retires one request for every region.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic [1:0] {
    ST_SPAWN   = 2'd0,
    ST_REPLACE = 2'd1,
    ST_DROP    = 2'd2
  } tsqStatusE;

  typedef struct packed {
    logic take;
    logic purge;
  } tsqStrobeT;
endpackage

// File: rtl/tsq_store.sv
module tsq_store
  import tsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PC_W   = 32,
  parameter int REG_W  = 4,
  parameter int ADDR_W = 32,
  parameter int ARG_W  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [PC_W-1:0]   pushPc,
  input  logic [REG_W-1:0]  pushRegion,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [ARG_W-1:0]  pushArg,
  input  tsqStrobeT         strobe,
  input  logic [DEPTH-1:0]  takeSel,
  input  logic [REG_W-1:0]  purgeRegion,
  output logic [DEPTH-1:0]  qVld,
  output logic [PC_W-1:0]   qPc   [DEPTH],
  output logic [REG_W-1:0]  qRgn  [DEPTH],
  output logic [ADDR_W-1:0] qAddr [DEPTH],
  output logic [ARG_W-1:0]  qArg  [DEPTH],
  output logic [CNT_W-1:0]  count
);
  logic [DEPTH-1:0]  keep;
  logic [DEPTH-1:0]  nVld;
  logic [PC_W-1:0]   nPc   [DEPTH];
  logic [REG_W-1:0]  nRgn  [DEPTH];
  logic [ADDR_W-1:0] nAddr [DEPTH];
  logic [ARG_W-1:0]  nArg  [DEPTH];
  logic [CNT_W-1:0]  pos;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      keep[i] = qVld[i]
              && !(strobe.purge && (qRgn[i] == purgeRegion))
              && !(strobe.take && takeSel[i]);
    end
  end

  // Compaction: surviving entries slide toward slot 0 in age order.
  always_comb begin
    nVld  = '0;
    nPc   = qPc;
    nRgn  = qRgn;
    nAddr = qAddr;
    nArg  = qArg;
    pos   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        nVld[pos[IDX_W-1:0]]  = 1'b1;
        nPc[pos[IDX_W-1:0]]   = qPc[i];
        nRgn[pos[IDX_W-1:0]]  = qRgn[i];
        nAddr[pos[IDX_W-1:0]] = qAddr[i];
        nArg[pos[IDX_W-1:0]]  = qArg[i];
        pos = pos + CNT_W'(1);
      end
    end
    if (pushEn && (pos < CNT_W'(DEPTH))) begin
      nVld[pos[IDX_W-1:0]]  = 1'b1;
      nPc[pos[IDX_W-1:0]]   = pushPc;
      nRgn[pos[IDX_W-1:0]]  = pushRegion;
      nAddr[pos[IDX_W-1:0]] = pushAddr;
      nArg[pos[IDX_W-1:0]]  = pushArg;
      pos = pos + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qVld  <= '0;
      count <= '0;
    end else begin
      qVld  <= nVld;
      count <= pos;
    end
  end

  always_ff @(posedge clk) begin
    qPc   <= nPc;
    qRgn  <= nRgn;
    qAddr <= nAddr;
    qArg  <= nArg;
  end
endmodule

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
  import tsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NCTX   = 4,
  parameter int PC_W   = 32,
  parameter int REG_W  = 4,
  parameter int ADDR_W = 32,
  parameter int ARG_W  = 32,
  parameter int XFER   = 10,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int TMR_W = $clog2(XFER + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEPTH-1:0]  qVld,
  input  logic [PC_W-1:0]   qPc   [DEPTH],
  input  logic [REG_W-1:0]  qRgn  [DEPTH],
  input  logic [ADDR_W-1:0] qAddr [DEPTH],
  input  logic [ARG_W-1:0]  qArg  [DEPTH],
  input  logic              rmValid,
  input  logic [REG_W-1:0]  rmRegion,
  input  logic [NCTX-1:0]   ctxDone,
  output tsqStrobeT         strobe,
  output logic [DEPTH-1:0]  takeSel,
  output logic [REG_W-1:0]  purgeRegion,
  output logic [NCTX-1:0]   ctxBusy,
  output logic [NCTX-1:0]   abortVec,
  output logic              statusValid,
  output logic [1:0]        statusCode,
  output logic [REG_W-1:0]  statusRegion,
  output logic              launchValid,
  output logic [CTX_W-1:0]  launchCtx,
  output logic [PC_W-1:0]   launchPc,
  output logic [ADDR_W-1:0] launchAddr,
  output logic [ARG_W-1:0]  launchArg
);
  logic [NCTX-1:0]   cBusy;
  logic [REG_W-1:0]  cRgn  [NCTX];
  logic [ADDR_W-1:0] cAddr [NCTX];
  logic [PC_W-1:0]   cPc   [NCTX];
  logic [ARG_W-1:0]  cArg  [NCTX];
  logic [TMR_W-1:0]  cTmr  [NCTX];

  logic [DEPTH-1:0]  runHit, dupHit, eligible;
  logic [CTX_W-1:0]  dupCtx [DEPTH];
  logic              found, freeFound, isReplace, doAssign;
  logic [IDX_W-1:0]  sel;
  logic [CTX_W-1:0]  freeIdx, tgt;
  logic [NCTX-1:0]   assignK;

  // Per-entry conflict classification against occupied contexts.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      runHit[i] = 1'b0;
      dupHit[i] = 1'b0;
      dupCtx[i] = '0;
      for (int k = 0; k < NCTX; k++) begin
        if (cBusy[k] && (cRgn[k] == qRgn[i])) begin
          runHit[i] = 1'b1;
          if (cAddr[k] == qAddr[i]) begin
            dupHit[i] = 1'b1;
            dupCtx[i] = CTX_W'(k);
          end
        end
      end
      eligible[i] = qVld[i] && !(rmValid && (qRgn[i] == rmRegion))
                  && (!runHit[i] || dupHit[i]);
    end
  end

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (eligible[i] && !found) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int k = 0; k < NCTX; k++) begin
      if (!cBusy[k] && !freeFound) begin
        freeFound = 1'b1;
        freeIdx   = CTX_W'(k);
      end
    end
    isReplace = found && dupHit[sel];
    doAssign  = found && (isReplace || freeFound);
    tgt       = isReplace ? dupCtx[sel] : freeIdx;
    for (int k = 0; k < NCTX; k++) begin
      assignK[k] = doAssign && (tgt == CTX_W'(k));
    end
  end

  assign takeSel      = found ? (DEPTH'(1) << sel) : '0;
  assign strobe.take  = found;
  assign strobe.purge = rmValid;
  assign purgeRegion  = rmRegion;
  assign ctxBusy      = cBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cBusy        <= '0;
      abortVec     <= '0;
      statusValid  <= 1'b0;
      statusCode   <= ST_SPAWN;
      statusRegion <= '0;
      launchValid  <= 1'b0;
      launchCtx    <= '0;
      launchPc     <= '0;
      launchAddr   <= '0;
      launchArg    <= '0;
      for (int k = 0; k < NCTX; k++) begin
        cRgn[k]  <= '0;
        cAddr[k] <= '0;
        cPc[k]   <= '0;
        cArg[k]  <= '0;
        cTmr[k]  <= '0;
      end
    end else begin
      statusValid <= found;
      if (found) begin
        statusRegion <= qRgn[sel];
        statusCode   <= isReplace ? ST_REPLACE : (freeFound ? ST_SPAWN : ST_DROP);
      end
      abortVec    <= isReplace ? (NCTX'(1) << tgt) : '0;
      launchValid <= 1'b0;
      for (int k = 0; k < NCTX; k++) begin
        if (assignK[k]) begin
          cBusy[k] <= 1'b1;
          cRgn[k]  <= qRgn[sel];
          cAddr[k] <= qAddr[sel];
          cPc[k]   <= qPc[sel];
          cArg[k]  <= qArg[sel];
          cTmr[k]  <= TMR_W'(XFER);
        end else begin
          if (cTmr[k] == TMR_W'(1)) begin
            launchValid <= 1'b1;
            launchCtx   <= CTX_W'(k);
            launchPc    <= cPc[k];
            launchAddr  <= cAddr[k];
            launchArg   <= cArg[k];
          end
          if (cTmr[k] != '0) cTmr[k] <= cTmr[k] - TMR_W'(1);
          else if (ctxDone[k]) cBusy[k] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/thread_spawn_queue.sv
module thread_spawn_queue
  import tsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NCTX   = 4,
  parameter int PC_W   = 32,
  parameter int REG_W  = 4,
  parameter int ADDR_W = 32,
  parameter int ARG_W  = 32,
  parameter int XFER   = 10,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  output logic              enqReady,
  input  logic [PC_W-1:0]   enqPc,
  input  logic [REG_W-1:0]  enqRegion,
  input  logic [ADDR_W-1:0] enqAddr,
  input  logic [ARG_W-1:0]  enqArg,
  input  logic              rmValid,
  input  logic [REG_W-1:0]  rmRegion,
  input  logic [NCTX-1:0]   ctxDone,
  output logic [NCTX-1:0]   ctxBusy,
  output logic [NCTX-1:0]   abortVec,
  output logic              launchValid,
  output logic [CTX_W-1:0]  launchCtx,
  output logic [PC_W-1:0]   launchPc,
  output logic [ADDR_W-1:0] launchAddr,
  output logic [ARG_W-1:0]  launchArg,
  output logic              statusValid,
  output logic [1:0]        statusCode,
  output logic [REG_W-1:0]  statusRegion
);
  tsqStrobeT         strobe;
  logic [DEPTH-1:0]  takeSel;
  logic [REG_W-1:0]  purgeRegion;
  logic [DEPTH-1:0]  qVld;
  logic [PC_W-1:0]   qPc   [DEPTH];
  logic [REG_W-1:0]  qRgn  [DEPTH];
  logic [ADDR_W-1:0] qAddr [DEPTH];
  logic [ARG_W-1:0]  qArg  [DEPTH];
  logic [CNT_W-1:0]  pendCount;

  assign enqReady = (pendCount < CNT_W'(DEPTH));

  tsq_store #(
    .DEPTH(DEPTH), .PC_W(PC_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .ARG_W(ARG_W)
  ) u_store (
    .clk(clk), .rstN(rstN),
    .pushEn(enqValid && enqReady), .pushPc(enqPc), .pushRegion(enqRegion),
    .pushAddr(enqAddr), .pushArg(enqArg),
    .strobe(strobe), .takeSel(takeSel), .purgeRegion(purgeRegion),
    .qVld(qVld), .qPc(qPc), .qRgn(qRgn), .qAddr(qAddr), .qArg(qArg),
    .count(pendCount)
  );

  tsq_ctrl #(
    .DEPTH(DEPTH), .NCTX(NCTX), .PC_W(PC_W), .REG_W(REG_W),
    .ADDR_W(ADDR_W), .ARG_W(ARG_W), .XFER(XFER)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .qVld(qVld), .qPc(qPc), .qRgn(qRgn), .qAddr(qAddr), .qArg(qArg),
    .rmValid(rmValid), .rmRegion(rmRegion), .ctxDone(ctxDone),
    .strobe(strobe), .takeSel(takeSel), .purgeRegion(purgeRegion),
    .ctxBusy(ctxBusy), .abortVec(abortVec),
    .statusValid(statusValid), .statusCode(statusCode), .statusRegion(statusRegion),
    .launchValid(launchValid), .launchCtx(launchCtx), .launchPc(launchPc),
    .launchAddr(launchAddr), .launchArg(launchArg)
  );
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int DEPTH = 16,
  parameter int NCTX  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             enqValid,
  input logic             enqReady,
  input logic             rmValid,
  input logic [CNT_W-1:0] pendCount,
  input logic [NCTX-1:0]  ctxBusy,
  input logic [NCTX-1:0]  abortVec,
  input logic             launchValid,
  input logic [CTX_W-1:0] launchCtx,
  input logic             statusValid,
  input logic [1:0]       statusCode
);
  assert_count_cap_R1: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= CNT_W'(DEPTH));

  assert_spawn_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusCode == 2'd0) |-> (ctxBusy != '0));

  assert_launch_on_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    launchValid |-> ctxBusy[launchCtx]);

  assert_abort_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(abortVec));

  assert_replace_pairs_abort_R4: assert property (@(posedge clk) disable iff (!rstN)
    (abortVec != '0) == (statusValid && statusCode == 2'd1));

  assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusCode == 2'd2) |-> (abortVec == '0));

  assert_purge_shrinks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rmValid && !(enqValid && enqReady)) |=> (pendCount <= $past(pendCount)));
endmodule

bind thread_spawn_queue tsq_checker #(.DEPTH(DEPTH), .NCTX(NCTX)) u_chk (
  .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqReady(enqReady),
  .rmValid(rmValid), .pendCount(pendCount), .ctxBusy(ctxBusy),
  .abortVec(abortVec), .launchValid(launchValid), .launchCtx(launchCtx),
  .statusValid(statusValid), .statusCode(statusCode)
);

// File: tb/sim_thread_spawn_queue.sv
`timescale 1ns/1ps
module sim_thread_spawn_queue;
  localparam int DEPTH = 4, NCTX = 2, PC_W = 12, REG_W = 3, ADDR_W = 8, ARG_W = 8, XFER = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic enqValid = 1'b0, rmValid = 1'b0;
  logic [PC_W-1:0] enqPc = '0;
  logic [REG_W-1:0] enqRegion = '0, rmRegion = '0;
  logic [ADDR_W-1:0] enqAddr = '0;
  logic [ARG_W-1:0] enqArg = '0;
  logic [NCTX-1:0] ctxDone = '0;
  logic enqReady, launchValid, statusValid;
  logic [NCTX-1:0] ctxBusy, abortVec;
  logic [0:0] launchCtx;
  logic [PC_W-1:0] launchPc;
  logic [ADDR_W-1:0] launchAddr;
  logic [ARG_W-1:0] launchArg;
  logic [1:0] statusCode;
  logic [REG_W-1:0] statusRegion;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  thread_spawn_queue #(.DEPTH(DEPTH), .NCTX(NCTX), .PC_W(PC_W), .REG_W(REG_W),
    .ADDR_W(ADDR_W), .ARG_W(ARG_W), .XFER(XFER)) u0 (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqReady(enqReady),
    .enqPc(enqPc), .enqRegion(enqRegion), .enqAddr(enqAddr), .enqArg(enqArg),
    .rmValid(rmValid), .rmRegion(rmRegion), .ctxDone(ctxDone), .ctxBusy(ctxBusy),
    .abortVec(abortVec), .launchValid(launchValid), .launchCtx(launchCtx),
    .launchPc(launchPc), .launchAddr(launchAddr), .launchArg(launchArg),
    .statusValid(statusValid), .statusCode(statusCode), .statusRegion(statusRegion));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input int pc, input int rgn, input int addr, input int arg);
    enqValid = 1'b1; enqPc = PC_W'(pc); enqRegion = REG_W'(rgn);
    enqAddr = ADDR_W'(addr); enqArg = ARG_W'(arg);
    tick();
    enqValid = 1'b0;
  endtask

  task automatic finishCtx(input int k);
    ctxDone = NCTX'(1) << k;
    tick();
    ctxDone = '0;
  endtask

  task automatic expectStatus(input string req, input int code, input int rgn);
    chk(req, "statusValid", statusValid, 1);
    chk(req, "statusCode", statusCode, code);
    chk(req, "statusRegion", statusRegion, rgn);
  endtask

  // Called in the cycle the spawn/replace status is visible.
  task automatic expectLaunch(input string req, input int ctx, input int pc, input int addr, input int arg);
    for (int t = 1; t < XFER; t++) begin
      tick();
      chk(req, "launchValid early", launchValid, 0);
    end
    tick();
    chk(req, "launchValid", launchValid, 1);
    chk(req, "launchCtx", launchCtx, ctx);
    chk(req, "launchPc", launchPc, pc);
    chk(req, "launchAddr", launchAddr, addr);
    chk(req, "launchArg", launchArg, arg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "enqReady", enqReady, 1);
    chk("R11", "statusValid", statusValid, 0);
    chk("R11", "launchValid", launchValid, 0);
    chk("R11", "abortVec", abortVec, 0);
    chk("R11", "ctxBusy", ctxBusy, 0);

    // R2/R3/R9 sweep across all regions on an idle pool
    for (int r = 0; r < 8; r++) begin
      push(16'h100 + r, r, r * 3, 8'hA0 + r);
      tick();
      expectStatus("R2", 0, r);
      chk("R2", "ctxBusy", ctxBusy, 2'b01);
      expectLaunch("R3", 0, 16'h100 + r, r * 3, 8'hA0 + r);
      tick();
      chk("R3", "launch single pulse", launchValid, 0);
      finishCtx(0);
      chk("R9", "ctx freed after done", ctxBusy, 0);
    end

    // R9 done during transfer ignored; R4 replace in the cycle the old launch was due
    push(12'h200, 1, 5, 8'h11);
    tick();
    expectStatus("R2", 0, 1);
    finishCtx(0);
    chk("R9", "done ignored in transfer", ctxBusy, 2'b01);
    push(12'h201, 1, 5, 8'h12);
    tick();
    expectStatus("R4", 1, 1);
    chk("R4", "abortVec", abortVec, 2'b01);
    chk("R4", "old launch suppressed", launchValid, 0);
    expectLaunch("R4", 0, 12'h201, 5, 8'h12);

    // R5 wait and R6 bypass by another region
    push(12'h202, 1, 6, 8'h13);
    tick();
    chk("R5", "waiting gives no status", statusValid, 0);
    push(12'h300, 2, 1, 8'h21);
    tick();
    expectStatus("R6", 0, 2);
    chk("R6", "ctxBusy", ctxBusy, 2'b11);
    expectLaunch("R6", 1, 12'h300, 1, 8'h21);
    finishCtx(0);
    tick();
    expectStatus("R5", 0, 1);
    expectLaunch("R5", 0, 12'h202, 6, 8'h13);

    // R7 drop when pool is full
    push(12'h400, 3, 2, 8'h31);
    tick();
    expectStatus("R7", 2, 3);
    chk("R7", "no abort", abortVec, 0);
    for (int t = 0; t <= XFER; t++) begin
      tick();
      chk("R7", "no launch", launchValid, 0);
    end
    chk("R7", "ctxBusy unchanged", ctxBusy, 2'b11);
    chk("R7", "entry removed", enqReady, 1);

    // R1 backpressure, R8 purge, R10 age order
    push(12'h500, 1, 9, 8'h41);
    push(12'h501, 2, 9, 8'h42);
    push(12'h502, 1, 10, 8'h43);
    push(12'h503, 2, 12, 8'h44);
    chk("R1", "full deasserts ready", enqReady, 0);
    enqValid = 1'b1; enqPc = 12'h504; enqRegion = 3'd2; enqAddr = 8'd11; enqArg = 8'h45;
    tick();
    tick();
    chk("R1", "still stalled", enqReady, 0);
    rmValid = 1'b1; rmRegion = 3'd1;
    tick();
    rmValid = 1'b0;
    chk("R8", "space after purge", enqReady, 1);
    tick();
    enqValid = 1'b0;
    finishCtx(0);
    tick();
    chk("R8", "purged region not dispatched", statusValid, 0);
    tick();
    chk("R8", "purged region not dispatched later", statusValid, 0);
    finishCtx(1);
    tick();
    expectStatus("R10", 0, 2);
    chk("R10", "ctxBusy", ctxBusy, 2'b01);
    expectLaunch("R10", 0, 12'h501, 9, 8'h42);
    tick();
    chk("R5", "younger same-region entries wait", statusValid, 0);
    chk("R1", "held push was kept", enqReady, 1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule